// File: doc/BRIEF.md
# Link-Layer Interrupt Event Register

This block gathers the interrupt-worthy events of a serial-bus link controller into one 32-bit event word. Single-cycle strobes from the link core, the DMA contexts and the PHY interface set sticky bits. Software reads the word, clears bits through a write-one-to-clear address, and can force bits through a write-one-to-set address. A separate 32-bit mask word selects which event bits drive the interrupt line.

Several bits follow rules beyond plain latching. A bus reset clears the self-ID completion flag on the same clock edge that sets the bus-reset flag. A shadow completion flag is set together with the self-ID flag and survives bus resets. Two bits watch slowly changing counter bits and latch on any change of level. Two further bits are not latched at all. Each one shows, at every instant, whether any isochronous context of its direction has an event that is enabled in its mask.

Top module: `lnk_irq_event_reg`

## Requirements
- R1: After reset, the event word reads 0, the mask word reads 0 and `irq` is 0.
- R2: A one-cycle strobe on `ev_strobe` at bit 0–5, 8, 9, 16, 17, 18, 19 or 22 sets that event bit at the next clock edge. The bit then holds until it is cleared.
- R3: Writing to address 2 clears every latched bit that has a 1 in `reg_wdata`. If an event for a bit arrives in the same cycle as its clear, the event wins and the bit ends up set.
- R4: Writing to address 1 sets every latched bit (0–5, 8, 9, 15–22) that has a 1 in `reg_wdata`.
- R5: Bits 10–14 and 23–31 always read 0. Strobes or set-port writes at those positions, and strobes at bits 6, 7, 15, 20 and 21, have no effect.
- R6: Bit 16 (self-ID complete) is 0 after any clock edge at which bit 17 (bus reset) is set, by strobe or by set port. This holds even when a self-ID strobe arrives in the same cycle.
- R7: Bit 15 is set whenever bit 16 is set by strobe or set port, including when a bus reset suppresses bit 16. A bus reset never clears bit 15.
- R8: Bit 20 is set at the clock edge after `cyc_cnt_lsb` changes level, in either direction. A steady level sets nothing.
- R9: Bit 21 is set at the clock edge after `cyc_sec_bit6` changes level, in either direction.
- R10: Bit 7 equals the OR of (`isorx_event` AND `isorx_mask`). Bit 6 equals the OR of (`isotx_event` AND `isotx_mask`). Both follow their inputs with no clock delay, and writes to the set or clear port do not change them.
- R11: `irq` equals the OR over all bits of (event word AND mask word).
- R12: Writing to address 3 loads the mask word. Reading address 3 returns the mask word, and reading addresses 0–2 returns the event word, both on `reg_rdata` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 32 | One-cycle event strobes, one per bit position |
| cyc_cnt_lsb | input | 1 | Least-significant bit of the cycle count |
| cyc_sec_bit6 | input | 1 | Bit 6 of the cycle-seconds counter |
| isorx_event | input | NUM_IR_CTX | Per-context isochronous receive event bits |
| isorx_mask | input | NUM_IR_CTX | Per-context isochronous receive mask bits |
| isotx_event | input | NUM_IT_CTX | Per-context isochronous transmit event bits |
| isotx_mask | input | NUM_IT_CTX | Per-context isochronous transmit mask bits |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | 0 read event, 1 set port, 2 clear port, 3 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, selected by reg_addr |
| irq | output | 1 | Interrupt: any masked event bit set |

## Verification
Two pairs of functions can act on the same bit in the same cycle.

The first pair is an event strobe and a software clear. The bench raises a strobe and writes the clear port with that bit in the same cycle. It judges the outcome by reading back a set bit, while a neighbouring bit cleared in the same write reads 0.

The second pair is a bus reset and a self-ID completion. The bench strobes both at once and expects bus reset set, self-ID clear and the shadow flag set. It repeats the collision using a set-port write of the bus-reset bit while self-ID is already set.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;

   localparam int EVT_W = 32;

   typedef enum logic [1:0] {
      RA_EVENT = 2'd0,
      RA_SET   = 2'd1,
      RA_CLEAR = 2'd2,
      RA_MASK  = 2'd3
   } reg_addr_e;

   // Bit positions that other logic decodes
   localparam int B_ITX     = 6;
   localparam int B_IRX     = 7;
   localparam int B_SID2    = 15;
   localparam int B_SID     = 16;
   localparam int B_BUSRST  = 17;
   localparam int B_CYCSYN  = 20;
   localparam int B_SEC64   = 21;

   // Bits that a hardware strobe may set directly
   localparam logic [EVT_W-1:0] STROBE_MASK = 32'h004F_033F;
   // Bits held in flops (strobe bits plus the shadow and toggle bits)
   localparam logic [EVT_W-1:0] STICKY_MASK = 32'h007F_833F;

endpackage

// File: rtl/lnk_irq_toggle_det.sv
module lnk_irq_toggle_det #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level_i,
   output logic [W-1:0] changed_o
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   assign changed_o = level_i ^ prev_q;

endmodule

// File: rtl/lnk_irq_ctx_summary.sv
module lnk_irq_ctx_summary #(
   parameter int N = 4
) (
   input  logic [N-1:0] ev_i,
   input  logic [N-1:0] mask_i,
   output logic         any_o
);

   generate
      if (N == 1) begin : g_single
         assign any_o = ev_i[0] & mask_i[0];
      end else begin : g_multi
         logic [N-1:0] hit;
         assign hit   = ev_i & mask_i;
         assign any_o = |hit;
      end
   endgenerate

endmodule

// File: rtl/lnk_irq_sticky_bank.sv
module lnk_irq_sticky_bank #(
   parameter int           W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [W-1:0] force_i,
   output logic [W-1:0] q_o
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_ff
            logic q;
            // priority: forced clear, then set, then software clear
            always_ff @(posedge clk) begin
               if (!rst_n)          q <= 1'b0;
               else if (force_i[i]) q <= 1'b0;
               else if (set_i[i])   q <= 1'b1;
               else if (clr_i[i])   q <= 1'b0;
            end
            assign q_o[i] = q;
         end else begin : g_tie
            logic unused_in;
            assign unused_in = set_i[i] ^ clr_i[i] ^ force_i[i];
            assign q_o[i]    = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/lnk_irq_event_reg.sv
module lnk_irq_event_reg
   import lnk_irq_pkg::*;
#(
   parameter int NUM_IR_CTX = 4,
   parameter int NUM_IT_CTX = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EVT_W-1:0]      ev_strobe,
   input  logic                  cyc_cnt_lsb,
   input  logic                  cyc_sec_bit6,
   input  logic [NUM_IR_CTX-1:0] isorx_event,
   input  logic [NUM_IR_CTX-1:0] isorx_mask,
   input  logic [NUM_IT_CTX-1:0] isotx_event,
   input  logic [NUM_IT_CTX-1:0] isotx_mask,
   input  logic                  reg_wr,
   input  logic [1:0]            reg_addr,
   input  logic [EVT_W-1:0]      reg_wdata,
   output logic [EVT_W-1:0]      reg_rdata,
   output logic                  irq
);

   localparam int MAX_CTX = 32;

   generate
      if (NUM_IR_CTX < 1 || NUM_IR_CTX > MAX_CTX) begin : g_bad_ir
         $error("NUM_IR_CTX out of range");
      end
      if (NUM_IT_CTX < 1 || NUM_IT_CTX > MAX_CTX) begin : g_bad_it
         $error("NUM_IT_CTX out of range");
      end
      if (EVT_W != 32) begin : g_bad_w
         $error("event word must be 32 bits");
      end
   endgenerate

   reg_addr_e        addr;
   logic [EVT_W-1:0] sw_set, sw_clr;
   logic [EVT_W-1:0] src, set_vec, force_vec;
   logic [EVT_W-1:0] latched, evt_view, mask_q;
   logic [1:0]       toggled;
   logic             rx_any, tx_any;
   logic             unused_strobes;

   assign addr   = reg_addr_e'(reg_addr);
   assign sw_set = (reg_wr && addr == RA_SET)   ? reg_wdata : '0;
   assign sw_clr = (reg_wr && addr == RA_CLEAR) ? reg_wdata : '0;

   assign unused_strobes = ^(ev_strobe & ~STROBE_MASK);

   lnk_irq_toggle_det #(.W(2)) u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   ({cyc_sec_bit6, cyc_cnt_lsb}),
      .changed_o (toggled)
   );

   assign src = (ev_strobe & STROBE_MASK) | sw_set;

   // cross-bit coupling
   always_comb begin
      set_vec            = src;
      set_vec[B_CYCSYN]  = src[B_CYCSYN] | toggled[0];
      set_vec[B_SEC64]   = src[B_SEC64]  | toggled[1];
      set_vec[B_SID2]    = src[B_SID2]   | src[B_SID];
      force_vec          = '0;
      force_vec[B_SID]   = src[B_BUSRST];
   end

   lnk_irq_sticky_bank #(.W(EVT_W), .IMPL(STICKY_MASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (sw_clr),
      .force_i (force_vec),
      .q_o     (latched)
   );

   lnk_irq_ctx_summary #(.N(NUM_IR_CTX)) u_rx_sum (
      .ev_i   (isorx_event),
      .mask_i (isorx_mask),
      .any_o  (rx_any)
   );

   lnk_irq_ctx_summary #(.N(NUM_IT_CTX)) u_tx_sum (
      .ev_i   (isotx_event),
      .mask_i (isotx_mask),
      .any_o  (tx_any)
   );

   always_comb begin
      evt_view        = latched;
      evt_view[B_ITX] = tx_any;
      evt_view[B_IRX] = rx_any;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        mask_q <= '0;
      else if (reg_wr && addr == RA_MASK) mask_q <= reg_wdata;
   end

   assign reg_rdata = (addr == RA_MASK) ? mask_q : evt_view;
   assign irq       = |(evt_view & mask_q);

endmodule

// File: rtl/lnk_irq_event_chk.sv
module lnk_irq_event_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] ev_strobe,
   input logic        cyc_cnt_lsb,
   input logic        reg_wr,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic [31:0] evt_view
);

   // R2 R3
   strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_strobe[0] |=> evt_view[0]);

   // R6
   busrst_kills_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_strobe[17] |=> (evt_view[17] && !evt_view[16]));

   // R7
   sid_shadow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_strobe[16] |=> evt_view[15]);

   // R7
   sid_shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_view[15] && !(reg_wr && reg_addr == 2'd2 && reg_wdata[15]))
      |=> evt_view[15]);

   // R8
   cyc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cyc_cnt_lsb) || $fell(cyc_cnt_lsb)) |=> evt_view[20]);

   // R5
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != 2'd3) |-> (reg_rdata[14:10] == 5'd0));

endmodule

bind lnk_irq_event_reg lnk_irq_event_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_strobe   (ev_strobe),
   .cyc_cnt_lsb (cyc_cnt_lsb),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .evt_view    (evt_view)
);

// File: tb/lnk_irq_event_reg_test.sv
module lnk_irq_event_reg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ev_strobe = '0;
   logic        cyc_cnt_lsb = 1'b0;
   logic        cyc_sec_bit6 = 1'b0;
   logic [3:0]  isorx_event = '0, isorx_mask = '0;
   logic [3:0]  isotx_event = '0, isotx_mask = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   lnk_irq_event_reg #(.NUM_IR_CTX(4), .NUM_IT_CTX(4)) uut (
      .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe),
      .cyc_cnt_lsb(cyc_cnt_lsb), .cyc_sec_bit6(cyc_sec_bit6),
      .isorx_event(isorx_event), .isorx_mask(isorx_mask),
      .isotx_event(isotx_event), .isotx_mask(isotx_mask),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk);
      ev_strobe = v;
      @(negedge clk);
      ev_strobe = '0;
   endtask

   task automatic clear_all();
      wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(2'd0, d); chk("R1 event after reset", d, 32'h0);
      rd(2'd3, d); chk("R1 mask after reset", d, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      pulse(32'h0044_0327);
      rd(2'd0, d); chk("R2 strobes latch", d, 32'h0044_0327);
      repeat (5) @(negedge clk);
      rd(2'd0, d); chk("R2 bits hold", d, 32'h0044_0327);
      pulse(32'h0008_0000);
      rd(2'd0, d); chk("R2 bit19 latch", d, 32'h004C_0327);
      pulse(32'hFFB0_FCC0);
      rd(2'd0, d); chk("R5 strobes at non-event bits ignored", d, 32'h004C_0327);
   endtask

   task automatic t_ports();
      logic [31:0] d;
      wr(2'd2, 32'h0000_0021);
      rd(2'd0, d); chk("R3 w1c clears selected bits", d, 32'h004C_0306);
      wr(2'd1, 32'h0000_0010);
      rd(2'd0, d); chk("R4 w1s sets bit4", d, 32'h004C_0316);
      wr(2'd1, 32'hFF80_7CC0);
      rd(2'd0, d); chk("R5 R10 set of reserved and computed bits ignored", d, 32'h004C_0316);
      clear_all();
      rd(2'd0, d); chk("R3 clear all", d, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      wr(2'd1, 32'h0000_0008);
      @(negedge clk);
      ev_strobe = 32'h0000_0004;
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_000C;
      @(negedge clk);
      ev_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(2'd0, d); chk("R3 event beats clear in same cycle", d, 32'h0000_0004);
      clear_all();
   endtask

   task automatic t_selfid();
      logic [31:0] d;
      pulse(32'h0001_0000);
      rd(2'd0, d); chk("R7 self-id sets shadow", d, 32'h0001_8000);
      pulse(32'h0002_0000);
      rd(2'd0, d); chk("R6 R7 bus reset clears self-id, keeps shadow", d, 32'h0002_8000);
      clear_all();
      pulse(32'h0003_0000);
      rd(2'd0, d); chk("R6 bus reset and self-id same cycle", d, 32'h0002_8000);
      clear_all();
      pulse(32'h0001_0000);
      wr(2'd1, 32'h0002_0000);
      rd(2'd0, d); chk("R6 set-port bus reset clears self-id", d, 32'h0002_8000);
      clear_all();
   endtask

   task automatic t_toggle();
      logic [31:0] d;
      @(negedge clk); cyc_cnt_lsb = 1'b1;
      @(negedge clk);
      rd(2'd0, d); chk("R8 rising cycle lsb", d, 32'h0010_0000);
      clear_all();
      repeat (3) @(negedge clk);
      rd(2'd0, d); chk("R8 steady level sets nothing", d, 32'h0);
      @(negedge clk); cyc_cnt_lsb = 1'b0;
      @(negedge clk);
      rd(2'd0, d); chk("R8 falling cycle lsb", d, 32'h0010_0000);
      clear_all();
      @(negedge clk); cyc_sec_bit6 = 1'b1;
      @(negedge clk);
      rd(2'd0, d); chk("R9 seconds bit change", d, 32'h0020_0000);
      clear_all();
      @(negedge clk); cyc_sec_bit6 = 1'b0; cyc_cnt_lsb = 1'b1;
      @(negedge clk);
      rd(2'd0, d); chk("R8 R9 both change", d, 32'h0030_0000);
      clear_all();
   endtask

   task automatic t_iso();
      logic [31:0] d;
      @(negedge clk); isorx_event = 4'b0100; isorx_mask = 4'b0000;
      rd(2'd0, d); chk("R10 unmasked rx event hidden", d, 32'h0);
      isorx_mask = 4'b0110;
      rd(2'd0, d); chk("R10 masked rx event shown", d, 32'h0000_0080);
      wr(2'd2, 32'h0000_00C0);
      rd(2'd0, d); chk("R10 clear of computed bit ignored", d, 32'h0000_0080);
      isotx_event = 4'b1001; isotx_mask = 4'b1000;
      rd(2'd0, d); chk("R10 tx summary", d, 32'h0000_00C0);
      isorx_event = 4'b0000;
      rd(2'd0, d); chk("R10 rx summary follows input", d, 32'h0000_0040);
      isotx_event = '0; isotx_mask = '0; isorx_mask = '0;
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(2'd3, 32'h0000_0001);
      rd(2'd3, d); chk("R12 mask readback", d, 32'h0000_0001);
      chk("R11 irq idle", {31'b0, irq}, 32'h0);
      pulse(32'h0000_0001);
      #1; chk("R11 irq on masked event", {31'b0, irq}, 32'h1);
      pulse(32'h0000_0002);
      wr(2'd2, 32'h0000_0001);
      #1; chk("R11 unmasked event gives no irq", {31'b0, irq}, 32'h0);
      wr(2'd3, 32'h0000_0040);
      @(negedge clk); isotx_event = 4'b0001; isotx_mask = 4'b0001;
      #1; chk("R11 irq from tx summary", {31'b0, irq}, 32'h1);
      rd(2'd0, d); chk("R12 event read at addr 0", d, 32'h0000_0042);
      isotx_event = '0; isotx_mask = '0;
      clear_all();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sticky();
      t_ports();
      t_race();
      t_selfid();
      t_toggle();
      t_iso();
      t_irq();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule